// File: doc/BRIEF.md
# Descrambler Lock Tracker

This block decides whether a receive-side self-synchronizing descrambler has locked to the scrambler sequence sent by the far end. It watches four things: a flag saying that TC delineation is in place, a strobe for each received TC, a strobe marking the TC that closes a frame, and a result bit saying whether the received scrambler bits matched the bits the descrambler predicted.

From these inputs it runs a three-state machine: hunt, pre-sync and sync. A single confidence counter drives the moves between states. In pre-sync the counter rises on good TCs. In sync it falls on good frames and rises on bad ones. Two programmable thresholds set when the machine gains and loses lock.

The block has three outputs: a one-cycle pulse that tells the descrambler to load its seed, a locked flag, and a request bit returned to the far end. While the request bit is set, the far end fills idle cells with its scrambler sequence instead of sending traffic. The descrambler datapath, the polynomial and the register access all sit outside this block. The thresholds arrive as plain input ports, and the configuration logic is expected to drive 8 on both after reset.

Top module: `dsl_lock_ctrl`

## Requirements
- R1: During and right after reset the machine is in hunt, with `locked` = 0, `far_req` = 1 and `seed_load` = 0.
- R2: In hunt, when `tc_aligned` is 1, the next clock edge moves the machine to pre-sync, sets the counter to 1 and raises `seed_load` for exactly one cycle.
- R3: In pre-sync, each cycle with `tc_stb` = 1 raises the counter by one when `cmp_ok` = 1 and lowers it by one when `cmp_ok` = 0. Cycles without `tc_stb` leave the counter unchanged.
- R4: In pre-sync, a counter update that reaches the enter threshold or more moves the machine to sync, sets `locked` and clears the counter. An update that brings the counter to 0 returns the machine to hunt.
- R5: In sync, a comparison counts only when `tc_stb` and `frame_stb` are both 1. A good result (`cmp_ok` = 1) lowers the counter, but never below 0. A bad result raises it.
- R6: In sync, a counter update that reaches the exit threshold or more returns the machine to hunt and clears `locked`.
- R7: When `tc_aligned` is 0, the machine is in hunt with `locked` = 0 after the next clock edge, whatever its state was.
- R8: In hunt, compare strobes and results have no effect. While `tc_aligned` is 0, `locked` stays 0 and `seed_load` stays 0.
- R9: `far_req` is 1 in every cycle where `locked` is 0, and 0 in every cycle where `locked` is 1.
- R10: Both thresholds are 4-bit unsigned values in the range 1 to 15. A value of 0 acts as 1. With an enter threshold of 15, lock needs 14 good TCs after entry to pre-sync. With an exit threshold of 15, lock is lost on the 15th net bad frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_aligned | input | 1 | TC delineation is in place |
| tc_stb | input | 1 | One TC comparison is available this cycle |
| frame_stb | input | 1 | This TC closes a frame |
| cmp_ok | input | 1 | Received scrambler bits matched the prediction |
| enter_thr | input | TW | Counter value that grants lock in pre-sync |
| exit_thr | input | TW | Counter value that drops lock in sync |
| seed_load | output | 1 | One-cycle pulse: descrambler loads the received seed |
| locked | output | 1 | Descrambler is locked |
| far_req | output | 1 | Request bit to the far end: send the scrambler sequence in idle cells |

## Verification
The bench builds the block with the default 4-bit threshold width. The vector table uses small thresholds (3 to enter, 2 to leave), so every transition is reached in a few cycles. These include entry, a fallback from pre-sync through zero, counter saturation at 0 in sync, loss of lock, and loss of alignment. The directed tests then drive the two extremes of the width, 0 and 15, to check that 0 is treated as 1 and that the longest count to lock and to loss of lock comes out exactly right.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_SYNC = 2'd2
    } dsl_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } dsl_step_e;
endpackage

// File: rtl/dsl_thr_floor.sv
module dsl_thr_floor #(
    parameter int TW = 4
) (
    input  logic [TW-1:0] thr_raw,
    output logic [TW-1:0] thr_eff
);
    localparam logic [TW-1:0] ONE = TW'(1);

    // a zero threshold would fire on the reset value of the counter: floor it at one
    always_comb begin
        thr_eff = (thr_raw == '0) ? ONE : thr_raw;
    end

    always_comb begin
        a_r10_floor_nonzero: assert (thr_eff != '0);
    end
endmodule

// File: rtl/dsl_conf_step.sv
module dsl_conf_step #(
    parameter int CW = 4
) (
    input  logic [CW-1:0]    cnt,
    input  dsl_pkg::dsl_step_e op,
    output logic [CW-1:0]    nxt,
    output logic             nxt_zero
);
    import dsl_pkg::*;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    // counter saturates at both ends
    always_comb begin
        unique case (op)
            STEP_UP:   nxt = (cnt == CMAX) ? CMAX : cnt + 1'b1;
            STEP_DOWN: nxt = (cnt == '0) ? '0 : cnt - 1'b1;
            default:   nxt = cnt;
        endcase
        nxt_zero = (nxt == '0);
    end
endmodule

// File: rtl/dsl_lock_ctrl.sv
module dsl_lock_ctrl #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tc_aligned,
    input  logic          tc_stb,
    input  logic          frame_stb,
    input  logic          cmp_ok,
    input  logic [TW-1:0] enter_thr,
    input  logic [TW-1:0] exit_thr,
    output logic          seed_load,
    output logic          locked,
    output logic          far_req
);
    import dsl_pkg::*;

    localparam int CW = TW;
    localparam int NTHR = 2;

    typedef struct packed {
        dsl_state_e    st;
        logic [CW-1:0] cnt;
        logic          load;
    } dsl_regs_t;

    dsl_regs_t r_d, r_q;

    logic [NTHR-1:0][TW-1:0] thr_raw;
    logic [NTHR-1:0][TW-1:0] thr_eff;
    logic [CW-1:0] step_val;
    logic          step_zero;
    dsl_step_e     step_op;
    logic          pre_cmp;
    logic          sync_cmp;

    assign thr_raw[0] = enter_thr;
    assign thr_raw[1] = exit_thr;

    for (genvar gi = 0; gi < NTHR; gi++) begin : g_thr
        dsl_thr_floor #(.TW(TW)) u_floor (
            .thr_raw (thr_raw[gi]),
            .thr_eff (thr_eff[gi])
        );
    end

    // which strobes count depends on the phase (R3, R5, R8)
    always_comb begin
        pre_cmp  = (r_q.st == ST_PRE) && tc_stb;
        sync_cmp = (r_q.st == ST_SYNC) && tc_stb && frame_stb;
        if (pre_cmp)
            step_op = cmp_ok ? STEP_UP : STEP_DOWN;
        else if (sync_cmp)
            step_op = cmp_ok ? STEP_DOWN : STEP_UP;
        else
            step_op = STEP_HOLD;
    end

    dsl_conf_step #(.CW(CW)) u_step (
        .cnt      (r_q.cnt),
        .op       (step_op),
        .nxt      (step_val),
        .nxt_zero (step_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (tc_aligned) begin
                    r_d.st   = ST_PRE;
                    r_d.cnt  = CW'(1);
                    r_d.load = 1'b1;
                end
            end
            ST_PRE: begin
                if (pre_cmp) begin
                    if (step_zero) begin
                        r_d.st  = ST_HUNT;
                        r_d.cnt = '0;
                    end else if (step_val >= thr_eff[0]) begin
                        r_d.st  = ST_SYNC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = step_val;
                    end
                end
            end
            ST_SYNC: begin
                if (sync_cmp) begin
                    if (step_val >= thr_eff[1]) begin
                        r_d.st  = ST_HUNT;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = step_val;
                    end
                end
            end
            default: begin
                r_d.st  = ST_HUNT;
                r_d.cnt = '0;
            end
        endcase
        if (!tc_aligned) begin
            r_d.st   = ST_HUNT;
            r_d.cnt  = '0;
            r_d.load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_HUNT;
            r_q.cnt  <= '0;
            r_q.load <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign seed_load = r_q.load;
    assign locked    = (r_q.st == ST_SYNC);
    assign far_req   = (r_q.st != ST_SYNC);

    a_r7_align_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_aligned |=> (r_q.st == ST_HUNT) && !locked);

    a_r2_load_follows_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HUNT && tc_aligned) |=> seed_load && (r_q.st == ST_PRE) && (r_q.cnt == CW'(1)));

    a_r2_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !seed_load);

    a_r3_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PRE && tc_aligned && !tc_stb) |=> (r_q.st == ST_PRE) && $stable(r_q.cnt));

    a_r3_pre_up: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PRE && tc_aligned && tc_stb && cmp_ok) |=>
            (r_q.st == ST_SYNC) || (r_q.cnt == $past(r_q.cnt) + 1'b1));

    a_r4_lock_from_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(r_q.st) == ST_PRE) && $past(tc_stb) && (r_q.cnt == '0));

    a_r5_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SYNC && tc_aligned && !(tc_stb && frame_stb)) |=> locked && $stable(r_q.cnt));

    a_r6_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !$past(tc_aligned) || ($past(tc_stb) && $past(frame_stb) && !$past(cmp_ok)));

    a_r9_req_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        far_req != locked);
endmodule

// File: tb/dsl_lock_ctrl_test.sv
`timescale 1ns/1ps
module dsl_lock_ctrl_test;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tc_aligned = 1'b0, tc_stb = 1'b0, frame_stb = 1'b0, cmp_ok = 1'b0;
    logic [TW-1:0] enter_thr = 4'd8, exit_thr = 4'd8;
    logic seed_load, locked, far_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsl_lock_ctrl #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tc_aligned(tc_aligned), .tc_stb(tc_stb),
        .frame_stb(frame_stb), .cmp_ok(cmp_ok), .enter_thr(enter_thr),
        .exit_thr(exit_thr), .seed_load(seed_load), .locked(locked), .far_req(far_req)
    );

    // {aligned, tc_stb, frame_stb, cmp_ok, exp_locked, exp_far_req, exp_seed_load}
    // enter threshold 3, exit threshold 2
    localparam int NV = 21;
    localparam logic [6:0] VEC [NV] = '{
        7'b0000_010,  // R1/R8 hunt stays
        7'b1000_011,  // R2 enter pre-sync, pulse
        7'b1101_010,  // R3 cnt 2
        7'b1100_010,  // R3 cnt 1
        7'b1000_010,  // R3 no strobe, cnt 1
        7'b1101_010,  // R3 cnt 2
        7'b1101_100,  // R4 cnt 3 -> sync
        7'b1100_100,  // R5 no frame strobe: ignored
        7'b1010_100,  // R5 frame without tc strobe: ignored
        7'b1111_100,  // R5 good frame, floor at 0
        7'b1110_100,  // R5 bad, cnt 1
        7'b1111_100,  // R5 good, cnt 0
        7'b1110_100,  // R5 bad, cnt 1
        7'b1110_010,  // R6 cnt 2 -> hunt
        7'b1000_011,  // R2 reload pulse
        7'b1100_010,  // R4 cnt 0 -> hunt
        7'b1000_011,  // R2 pre-sync again
        7'b1101_010,  // R3 cnt 2
        7'b1101_100,  // R4 lock
        7'b0111_010,  // R7 alignment lost
        7'b0101_010   // R8 strobes ignored in hunt
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic t, input logic f, input logic c);
        @(negedge clk);
        tc_aligned = a; tc_stb = t; frame_stb = f; cmp_ok = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 locked", locked, 1'b0);
        chk("R1 far_req", far_req, 1'b1);
        chk("R1 seed_load", seed_load, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        enter_thr = 4'd3;
        exit_thr = 4'd2;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            chk($sformatf("R4/R5 vec%0d locked", i), locked, VEC[i][2]);
            chk($sformatf("R9 vec%0d far_req", i), far_req, VEC[i][1]);
            chk($sformatf("R2 vec%0d seed_load", i), seed_load, VEC[i][0]);
        end

        // R10: enter threshold 15 needs 14 good TCs
        enter_thr = 4'd15;
        exit_thr = 4'd15;
        step(1, 0, 0, 0);
        chk("R2 pulse at max thr", seed_load, 1'b1);
        for (int k = 0; k < 13; k++) step(1, 1, 0, 1);
        chk("R10 not locked after 13", locked, 1'b0);
        step(1, 1, 0, 1);
        chk("R10 locked after 14", locked, 1'b1);
        // R10: exit threshold 15, 14 bad frames keep lock
        for (int k = 0; k < 14; k++) step(1, 1, 1, 0);
        chk("R10 still locked after 14 bad", locked, 1'b1);
        step(1, 1, 1, 0);
        chk("R10 unlocked on 15th bad", locked, 1'b0);
        chk("R9 far_req after unlock", far_req, 1'b1);

        // R10: zero thresholds act as one
        enter_thr = 4'd0;
        exit_thr = 4'd0;
        step(1, 0, 0, 0);
        step(1, 1, 0, 1);
        chk("R10 enter 0 as 1", locked, 1'b1);
        step(1, 1, 1, 1);
        chk("R10 exit 0: good frame keeps lock", locked, 1'b1);
        step(1, 1, 1, 0);
        chk("R10 exit 0: bad frame drops lock", locked, 1'b0);

        // R1: reset while locked
        step(1, 0, 0, 0);
        step(1, 1, 0, 1);
        chk("R4 relocked", locked, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset clears lock", locked, 1'b0);
        chk("R1 reset sets far_req", far_req, 1'b1);
        chk("R1 reset no pulse", seed_load, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule